// File: doc/BRIEF.md
# Sparse Ring Census Descriptor Generator

This block takes a raster-ordered stream of filtered 8-bit pixels, each beat tagged with its column and row, and turns it into a stream of 72-bit texture descriptors for a stereo matcher further down the pipeline. A first sliding window, five pixels square, is held in line buffers. For each position, eight samples on the outer ring are compared against the centre pixel to form an 8-bit signature. The inner pixels and the centre itself never reach the signature.

A second sliding window, three signatures square, is built from the signature stream with line buffers of the same row length. The nine signatures are packed into one descriptor. The descriptor leaves on the same beat-tagged interface as the input, labelled with the coordinates of the centre of the combined neighbourhood. A beat is produced only where both windows lie wholly inside the current frame. Gaps in the input valid line stall both windows without disturbing their contents.

Top module: `sparse_census_desc`

## Requirements
- R1: While reset is asserted, and after its release until the first qualifying beat, `out_valid` is 0 and `out_x`, `out_y` and `out_desc` are 0.
- R2: A signature bit is 1 when its ring sample is strictly lower than the centre pixel. A sample equal to or higher than the centre gives 0, so a flat image yields all-zero descriptors.
- R3: Signature bit b samples the pixel at offset (dx,dy) from the centre: b0 (-2,-2), b1 (0,-2), b2 (+2,-2), b3 (+2,0), b4 (+2,+2), b5 (0,+2), b6 (-2,+2), b7 (-2,0). This is clockwise from the top-left corner, with y growing downwards.
- R4: Pixels at any other offset of the 5x5 neighbourhood, including the centre's direct neighbours, do not affect the signature.
- R5: `out_desc[8*(3*r+c) +: 8]` holds the signature centred at (out_x-1+c, out_y-1+r) for r,c in 0..2. The top-left signature is in the lowest byte, and row-major order follows.
- R6: An input beat whose descriptor qualifies appears on the outputs exactly two clock cycles after the edge that accepted it. `out_valid` is high for one cycle per such beat and low otherwise.
- R7: A beat at (x,y) yields an output only when x >= 6 and y >= 6. The output carries coordinates (x-3, y-3).
- R8: Cycles with `in_valid` low advance neither window. Outputs hold their last values, and later descriptors are the same as for an unbroken stream.
- R9: The row length of both line buffers comes from the single parameter `IMG_W`. Every pixel of a frame must be delivered once, in raster order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat present |
| in_x | input | XW | Column of the input pixel |
| in_y | input | YW | Row of the input pixel |
| in_pix | input | 8 | Filtered pixel intensity |
| out_valid | output | 1 | Descriptor beat present |
| out_x | output | XW | Column of the descriptor centre |
| out_y | output | YW | Row of the descriptor centre |
| out_desc | output | 72 | Nine packed 8-bit ring signatures |

## Verification
Several kinds of frame are streamed through the block.

- A uniformly random frame exercises signatures and packing in general.
- A flat frame must give zero descriptors. It separates a strict comparison from one that also accepts equal values.
- A dot frame places isolated dark and bright pixels on a sparse lattice. Each dot lights a single signature bit, or none when it sits at an ignored offset. This pins down bit order, ring positions and byte order.
- A horizontal ramp checks the comparison direction.
- A random frame with frequent valid gaps must match the unbroken result. This shows that stalls neither shift the windows nor produce extra output beats.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int SIG_W  = 8;
  localparam int GRP    = 3;
  localparam int NTAP   = GRP * GRP;
  localparam int DESC_W = NTAP * SIG_W;

  // ring sample rows/cols, clockwise from top-left corner
  function automatic int ring_row(input int b, input int rad);
    case (b)
      0, 1, 2: return 0;
      3, 7:    return rad;
      default: return 2 * rad;
    endcase
  endfunction

  function automatic int ring_col(input int b, input int rad);
    case (b)
      0, 6, 7: return 0;
      1, 5:    return rad;
      default: return 2 * rad;
    endcase
  endfunction

  // distance from newest sample for tap i of a k-square window
  function automatic int tap_dist(input int sparse, input int i, input int k,
                                  input int line);
    int r, c;
    if (sparse != 0) begin
      if (i < 8) begin
        r = ring_row(i, (k - 1) / 2);
        c = ring_col(i, (k - 1) / 2);
      end else begin
        r = (k - 1) / 2;
        c = (k - 1) / 2;
      end
    end else begin
      r = i / k;
      c = i % k;
    end
    return (k - 1 - r) * line + (k - 1 - c);
  endfunction
endpackage

// File: rtl/sc_window.sv
module sc_window #(
  parameter int DW     = 8,
  parameter int K      = 3,
  parameter int LINE   = 32,
  parameter int SPARSE = 0,
  parameter int NT     = 9
) (
  input  logic             clk,
  input  logic             shift_en,
  input  logic [DW-1:0]    din,
  output logic [NT*DW-1:0] taps
);
  localparam int LEN = (K - 1) * LINE + K;

  logic [DW-1:0] sr   [LEN];
  logic [DW-1:0] sr_d [LEN];

  always_comb begin
    for (int i = 0; i < LEN; i++) sr_d[i] = sr[i];
    if (shift_en) begin
      sr_d[0] = din;
      for (int i = 1; i < LEN; i++) sr_d[i] = sr[i-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LEN; i++) sr[i] <= sr_d[i];
  end

  for (genvar t = 0; t < NT; t++) begin : g_tap
    localparam int D = sc_pkg::tap_dist(SPARSE, t, K, LINE);
    assign taps[t*DW +: DW] = sr[D];
  end
endmodule

// File: rtl/sc_census_cmp.sv
module sc_census_cmp #(
  parameter int DW = 8
) (
  input  logic [9*DW-1:0] ring,
  output logic [7:0]      sig
);
  logic [DW-1:0] ctr;
  assign ctr = ring[8*DW +: DW];

  for (genvar b = 0; b < 8; b++) begin : g_bit
    assign sig[b] = (ring[b*DW +: DW] < ctr);
  end
endmodule

// File: rtl/sparse_census_desc.sv
module sparse_census_desc
  import sc_pkg::*;
#(
  parameter int IMG_W = 32,
  parameter int XW    = 10,
  parameter int YW    = 10,
  parameter int RAD   = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              in_valid,
  input  logic [XW-1:0]     in_x,
  input  logic [YW-1:0]     in_y,
  input  logic [7:0]        in_pix,
  output logic              out_valid,
  output logic [XW-1:0]     out_x,
  output logic [YW-1:0]     out_y,
  output logic [DESC_W-1:0] out_desc
);
  localparam int K1    = 2 * RAD + 1;
  localparam int LAG   = RAD + (GRP - 1) / 2;
  localparam int FIRST = 2 * RAD + (GRP - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_n_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_meta <= 1'b0;
      rst_n_q  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_q  <= rst_meta;
    end
  end

  logic              s1_beat, s1_beat_d, s2_beat, s2_beat_d;
  logic [XW-1:0]     s1_x, s1_x_d, s2_x, s2_x_d, out_x_d;
  logic [YW-1:0]     s1_y, s1_y_d, s2_y, s2_y_d, out_y_d;
  logic              out_valid_d, fire;
  logic [DESC_W-1:0] out_desc_d;
  logic [9*8-1:0]    ring_taps;
  logic [SIG_W-1:0]  sig1;
  logic [DESC_W-1:0] grp_taps;

  sc_window #(.DW(8), .K(K1), .LINE(IMG_W), .SPARSE(1), .NT(9)) u_pix_win (
    .clk(clk), .shift_en(in_valid), .din(in_pix), .taps(ring_taps));

  sc_census_cmp #(.DW(8)) u_cmp (.ring(ring_taps), .sig(sig1));

  sc_window #(.DW(SIG_W), .K(GRP), .LINE(IMG_W), .SPARSE(0), .NT(NTAP)) u_sig_win (
    .clk(clk), .shift_en(s1_beat), .din(sig1), .taps(grp_taps));

  always_comb begin
    s1_beat_d = in_valid;
    s1_x_d    = in_valid ? in_x : s1_x;
    s1_y_d    = in_valid ? in_y : s1_y;
    s2_beat_d = s1_beat;
    s2_x_d    = s1_beat ? s1_x : s2_x;
    s2_y_d    = s1_beat ? s1_y : s2_y;
    fire      = s2_beat && (s2_x >= XW'(FIRST)) && (s2_y >= YW'(FIRST));
    out_valid_d = fire;
    out_x_d     = fire ? s2_x - XW'(LAG) : out_x;
    out_y_d     = fire ? s2_y - YW'(LAG) : out_y;
    out_desc_d  = fire ? grp_taps : out_desc;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      s1_beat   <= 1'b0;
      s1_x      <= '0;
      s1_y      <= '0;
      s2_beat   <= 1'b0;
      s2_x      <= '0;
      s2_y      <= '0;
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_desc  <= '0;
    end else begin
      s1_beat   <= s1_beat_d;
      s1_x      <= s1_x_d;
      s1_y      <= s1_y_d;
      s2_beat   <= s2_beat_d;
      s2_x      <= s2_x_d;
      s2_y      <= s2_y_d;
      out_valid <= out_valid_d;
      out_x     <= out_x_d;
      out_y     <= out_y_d;
      out_desc  <= out_desc_d;
    end
  end

  // R6: an output beat traces back to an input beat two edges earlier
  assert_lag_R6: assert property (@(posedge clk) disable iff (!rst_n_q)
    out_valid |-> $past(in_valid, 3));

  // R6: signature stage follows pixel stage by one edge
  assert_beat_chain_R6: assert property (@(posedge clk) disable iff (!rst_n_q)
    s1_beat |=> s2_beat);

  // R7: coordinates realigned to the combined window centre
  assert_coord_R7: assert property (@(posedge clk) disable iff (!rst_n_q)
    out_valid |-> (out_x == $past(in_x, 3) - XW'(LAG)) &&
                  (out_y == $past(in_y, 3) - YW'(LAG)));

  // R7: no output centre closer than LAG to the top/left edge
  assert_range_R7: assert property (@(posedge clk) disable iff (!rst_n_q)
    out_valid |-> (out_x >= XW'(FIRST - LAG)) && (out_y >= YW'(FIRST - LAG)));

  // R8: a stalled signature stage leaves the descriptor untouched
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_q)
    !s2_beat |=> $stable(out_desc) && !out_valid);
endmodule

// File: tb/tb_sparse_census_desc.sv
module tb_sparse_census_desc;
  localparam int W = 12;   // R9: non-default row length
  localparam int H = 10;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        in_valid;
  logic [9:0]  in_x, in_y;
  logic [7:0]  in_pix;
  logic        out_valid;
  logic [9:0]  out_x, out_y;
  logic [71:0] out_desc;

  always #5 clk = ~clk;

  sparse_census_desc #(.IMG_W(W), .XW(10), .YW(10), .RAD(2)) dut (
    .clk(clk), .arst_n(arst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_pix(in_pix), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
    .out_desc(out_desc));

  int checks = 0;
  int errors = 0;
  int img [H][W];
  string tag_extra = "";

  // expected outputs in flight: index 2 is due at the current negedge
  bit          ev [3];
  int          ex [3];
  int          ey [3];
  logic [71:0] ed [3];

  task automatic chk(input bit ok, input string tag, input logic [71:0] act,
                     input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s%s: actual %h expected %h", tag, tag_extra, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_sig(input int cx, input int cy);
    int dxs [8] = '{-2, 0, 2, 2, 2, 0, -2, -2};
    int dys [8] = '{-2, -2, -2, 0, 2, 2, 2, 0};
    logic [7:0] s;
    for (int b = 0; b < 8; b++)
      s[b] = (img[cy + dys[b]][cx + dxs[b]] < img[cy][cx]);
    return s;
  endfunction

  task automatic step(input bit v, input int x, input int y, input int p);
    @(negedge clk);
    chk(out_valid == ev[2], "R6 R7 valid", 72'(out_valid), 72'(ev[2]));
    if (ev[2]) begin
      chk(out_x == 10'(ex[2]) && out_y == 10'(ey[2]), "R7 coords",
          72'({out_x, out_y}), 72'({10'(ex[2]), 10'(ey[2])}));
      chk(out_desc == ed[2], "R2 R3 R4 R5 descriptor", out_desc, ed[2]);
    end
    for (int i = 2; i > 0; i--) begin
      ev[i] = ev[i-1]; ex[i] = ex[i-1]; ey[i] = ey[i-1]; ed[i] = ed[i-1];
    end
    in_valid = v;
    in_x = 10'(x);
    in_y = 10'(y);
    in_pix = 8'(p);
    ev[0] = 1'b0;
    if (v) begin
      img[y][x] = p;
      if (x >= 6 && y >= 6) begin
        ev[0] = 1'b1;
        ex[0] = x - 3;
        ey[0] = y - 3;
        for (int r = 0; r < 3; r++)
          for (int c = 0; c < 3; c++)
            ed[0][8*(3*r+c) +: 8] = ref_sig(x - 4 + c, y - 4 + r);
      end
    end
  endtask

  // kind: 0 random, 1 flat, 2 dots, 3 random with gaps, 4 ramp
  task automatic run_frame(input int kind);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int p;
        case (kind)
          0, 3: p = int'($urandom_range(0, 255));
          1: p = 77;
          2: p = ((x % 5) == 1 && (y % 4) == 2) ? 10 :
                 ((x % 7) == 3 && (y % 3) == 0) ? 240 : 120;
          default: p = x * 20;
        endcase
        if (kind == 3)
          while ($urandom_range(0, 2) == 0) step(1'b0, 0, 0, 0); // R8 gaps
        step(1'b1, x, y, p);
      end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      ev[i] = 1'b0; ex[i] = 0; ey[i] = 0; ed[i] = '0;
    end
    arst_n = 1'b0;
    in_valid = 1'b0; in_x = '0; in_y = '0; in_pix = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    chk(out_valid == 1'b0 && out_desc == '0 && out_x == '0 && out_y == '0,
        "R1 reset", out_desc, 72'd0);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_desc == '0, "R1 after release", out_desc, 72'd0);

    tag_extra = " [random]";  run_frame(0);
    tag_extra = " [flat R2]"; run_frame(1);
    tag_extra = " [dots R3 R4]"; run_frame(2);
    tag_extra = " [gaps R8]"; run_frame(3);
    tag_extra = " [ramp R2]"; run_frame(4);
    tag_extra = " [flush]";
    for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule